// File: doc/BRIEF.md
# Port Control-Line Output Generator

This block drives the second control line of each port of a parallel interface adapter while that line is set up as an output. Each port has its own control byte. Three bits of that byte pick how the line behaves:

- In manual mode the line holds a level that software programs.
- In strobe mode the line drops low when the port's data register is accessed.
- In strobe-with-restore mode the line drops low on the access and comes back high one enable cycle later.

The access that fires a strobe depends on the port. Port 0 strobes on a data read and port 1 strobes on a data write. Which ports strobe on writes is set by a parameter mask. The block runs on the enable clock, so one clock cycle is one enable cycle.

On every cycle the block takes in three things for each port. The first is the control write strobe and its data byte. The second is the data read and write strobes. The third is a one-cycle pulse that marks an active edge on the port's first control input. It returns three things for each port: the line level, a one-cycle pulse each time that level changes, and a flag that is high while the line is an output. A neighbouring status block uses that flag to force the line's interrupt-2 status bit to read as zero. Interrupt detection in input mode is left to other logic.

Top module: `hs2_out_gen`

## Requirements
- R1: After reset every line is high, no change pulse is present, and every output-mode flag is low.
- R2: Control byte bit 5 is the output enable. A control write with bit 5 = 1 sets the line to bit 3 of that same byte on the next cycle, whatever the submode.
- R3: The change pulse is high for exactly the cycles in which the line level differs from its value one cycle earlier.
- R4: On port 0, with bit 5 = 1 and bit 4 = 0 (strobe mode), a data read drives the line low on the next cycle. A data write has no effect.
- R5: On port 1, in strobe mode, a data write drives the line low on the next cycle. A data read has no effect.
- R6: In strobe mode with bit 3 = 1 (restore), the line is low for exactly one cycle after the access and then returns high.
- R7: In strobe mode with bit 3 = 0, the line stays low until a first-control-input pulse arrives, and goes high on the next cycle.
- R8: In manual mode (bit 5 = 1, bit 4 = 1), neither data accesses nor first-control-input pulses change the line.
- R9: While bit 5 = 0 (input mode), the line holds its level. Data accesses, first-control-input pulses and control writes with bit 5 = 0 do not change it.
- R10: The output-mode flag equals bit 5 of the most recent control write to that port, from the cycle after the write onward.
- R11: A control write takes priority over a data access in the same cycle. A data access takes priority over a first-control-input pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Enable clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | NUM_PORTS | Control register write strobe, one bit per port |
| ctl_wdata_i | input | NUM_PORTS*CTL_W | Control write data, port p in slice [p*CTL_W +: CTL_W] |
| data_rd_i | input | NUM_PORTS | Data register read strobe per port |
| data_wr_i | input | NUM_PORTS | Data register write strobe per port |
| c1_act_i | input | NUM_PORTS | One-cycle pulse for an active edge on the first control input |
| line_o | output | NUM_PORTS | Control line level |
| line_chg_o | output | NUM_PORTS | One-cycle pulse when the line level changes |
| c2_out_o | output | NUM_PORTS | Line is in output mode, so its interrupt-2 status bit reads zero |

## Verification
On every cycle the assertions check these properties:

- the level a control write programs;
- the low drive after a strobing access;
- the one-cycle restore;
- the hold in input and manual modes;
- the match between the change pulse and actual level changes;
- how the output flag tracks bit 5.

The bench scenarios are needed for the rest:

- the reset state;
- which access each port strobes on, including that the opposite access is ignored;
- the release of a held strobe by a first-control-input pulse;
- the priority when events arrive in the same cycle.

The bench covers all eight values of the three mode bits on both ports, each combined with each kind of stimulus.

// File: rtl/hs2_pkg.sv
package hs2_pkg;
  localparam int CTL_W   = 8;
  localparam int OUT_BIT = 5;
  localparam int SEL_BIT = 4;
  localparam int LVL_BIT = 3;

  typedef enum logic [1:0] {
    MODE_INPUT       = 2'd0,
    MODE_MANUAL      = 2'd1,
    MODE_STROBE      = 2'd2,
    MODE_STROBE_AUTO = 2'd3
  } c2_mode_e;

  function automatic c2_mode_e decode_mode(input logic out_en, input logic sel, input logic lvl);
    if (!out_en) return MODE_INPUT;
    if (sel) return MODE_MANUAL;
    return lvl ? MODE_STROBE_AUTO : MODE_STROBE;
  endfunction
endpackage

// File: rtl/hs2_ctl_reg.sv
module hs2_ctl_reg
  import hs2_pkg::*;
#(
  parameter int W = CTL_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output c2_mode_e     mode_o,
  output logic         wr_out_o,
  output logic         wr_lvl_o,
  output logic         out_en_o
);
  c2_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_INPUT;
    else if (we_i) mode_q <= decode_mode(wdata_i[OUT_BIT], wdata_i[SEL_BIT], wdata_i[LVL_BIT]);
  end

  assign mode_o   = mode_q;
  assign wr_out_o = we_i & wdata_i[OUT_BIT];
  assign wr_lvl_o = wdata_i[LVL_BIT];
  assign out_en_o = (mode_q != MODE_INPUT);

  AST_FLAG_TRACKS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> out_en_o == $past(wdata_i[OUT_BIT])); // R10
  AST_FLAG_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(out_en_o)); // R10
endmodule

// File: rtl/hs2_line.sv
module hs2_line
  import hs2_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ctl_we_i,
  input  logic     ctl_out_i,
  input  logic     ctl_lvl_i,
  input  c2_mode_e mode_i,
  input  logic     access_i,
  input  logic     c1_act_i,
  output logic     line_o,
  output logic     chg_o
);
  logic line_q, line_d, pend_q, pend_d, chg_q;

  always_comb begin
    line_d = line_q;
    pend_d = 1'b0;
    if (ctl_we_i) begin
      if (ctl_out_i) line_d = ctl_lvl_i;
    end else begin
      unique case (mode_i)
        MODE_STROBE: begin
          if (access_i) line_d = 1'b0;
          else if (c1_act_i) line_d = 1'b1;
        end
        MODE_STROBE_AUTO: begin
          if (access_i) begin
            line_d = 1'b0;
            pend_d = 1'b1;
          end else if (pend_q) begin
            line_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b1;
      pend_q <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      line_q <= line_d;
      pend_q <= pend_d;
      chg_q  <= line_d ^ line_q;
    end
  end

  assign line_o = line_q;
  assign chg_o  = chg_q;

  AST_WRITE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i && ctl_out_i |=> line_o == $past(ctl_lvl_i)); // R2
  AST_STROBE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_we_i && access_i && (mode_i == MODE_STROBE || mode_i == MODE_STROBE_AUTO) |=> !line_o); // R4
  AST_AUTO_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !ctl_we_i && !access_i |=> line_o); // R6
  AST_INPUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_we_i && mode_i == MODE_INPUT |=> $stable(line_o)); // R9
  AST_MANUAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_we_i && mode_i == MODE_MANUAL |=> $stable(line_o)); // R8
  AST_CHG_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(line_o) |-> chg_o); // R3
  AST_CHG_ONLY_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |-> !$stable(line_o)); // R3
endmodule

// File: rtl/hs2_out_gen.sv
module hs2_out_gen
  import hs2_pkg::*;
#(
  parameter int                 NUM_PORTS   = 2,
  parameter int                 W           = CTL_W,
  parameter logic [NUM_PORTS-1:0] STROBE_WR = 2'b10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_PORTS-1:0]   ctl_we_i,
  input  logic [NUM_PORTS*W-1:0] ctl_wdata_i,
  input  logic [NUM_PORTS-1:0]   data_rd_i,
  input  logic [NUM_PORTS-1:0]   data_wr_i,
  input  logic [NUM_PORTS-1:0]   c1_act_i,
  output logic [NUM_PORTS-1:0]   line_o,
  output logic [NUM_PORTS-1:0]   line_chg_o,
  output logic [NUM_PORTS-1:0]   c2_out_o
);
  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    c2_mode_e mode;
    logic     wr_out, wr_lvl, access;

    if (STROBE_WR[g]) begin : g_on_wr
      assign access = data_wr_i[g];
    end else begin : g_on_rd
      assign access = data_rd_i[g];
    end

    hs2_ctl_reg #(.W(W)) u_ctl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (ctl_we_i[g]),
      .wdata_i (ctl_wdata_i[g*W +: W]),
      .mode_o  (mode),
      .wr_out_o(wr_out),
      .wr_lvl_o(wr_lvl),
      .out_en_o(c2_out_o[g])
    );

    hs2_line u_line (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ctl_we_i (ctl_we_i[g]),
      .ctl_out_i(wr_out),
      .ctl_lvl_i(wr_lvl),
      .mode_i   (mode),
      .access_i (access),
      .c1_act_i (c1_act_i[g]),
      .line_o   (line_o[g]),
      .chg_o    (line_chg_o[g])
    );
  end
endmodule

// File: tb/hs2_out_gen_bench.sv
module hs2_out_gen_bench;
  localparam int P = 2;
  localparam int W = 8;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [P-1:0]   ctl_we_i = '0;
  logic [P*W-1:0] ctl_wdata_i = '0;
  logic [P-1:0]   data_rd_i = '0;
  logic [P-1:0]   data_wr_i = '0;
  logic [P-1:0]   c1_act_i = '0;
  logic [P-1:0]   line_o, line_chg_o, c2_out_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  hs2_out_gen u_hs2_out_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i),
    .data_rd_i(data_rd_i), .data_wr_i(data_wr_i), .c1_act_i(c1_act_i),
    .line_o(line_o), .line_chg_o(line_chg_o), .c2_out_o(c2_out_o)
  );

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic clr();
    ctl_we_i = '0; data_rd_i = '0; data_wr_i = '0; c1_act_i = '0;
  endtask

  task automatic set_ctl(input int p, input logic [7:0] v);
    ctl_we_i[p] = 1'b1;
    ctl_wdata_i[p*W +: W] = v;
  endtask

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic prev, expv, trig;
    logic [2:0] mb;
    #20 rst_ni = 1'b1;
    tick();
    for (int p = 0; p < P; p++) begin
      chk(line_o[p], 1'b1, "R1", "line after reset");
      chk(line_chg_o[p], 1'b0, "R1", "change pulse after reset");
      chk(c2_out_o[p], 1'b0, "R1", "output flag after reset");
    end

    // sweep: port x mode bits x stimulus (0 read, 1 write, 2 first-input pulse)
    for (int p = 0; p < P; p++) begin
      for (int m = 0; m < 8; m++) begin
        for (int s = 0; s < 3; s++) begin
          mb = m[2:0];
          clr(); set_ctl(p, 8'h38); tick();
          chk(line_o[p], 1'b1, "R2", "manual high preset");
          prev = 1'b1;
          clr(); set_ctl(p, {2'b00, mb, 3'b000}); tick();
          expv = mb[2] ? mb[0] : prev;
          chk(line_o[p], expv, mb[2] ? "R2" : "R9", "level after control write");
          chk(line_chg_o[p], expv ^ prev, "R3", "change after control write");
          chk(c2_out_o[p], mb[2], "R10", "output flag");
          prev = expv;
          clr();
          if (s == 0) data_rd_i[p] = 1'b1;
          if (s == 1) data_wr_i[p] = 1'b1;
          if (s == 2) c1_act_i[p] = 1'b1;
          tick();
          trig = mb[2] && !mb[1] && ((s == 0 && p == 0) || (s == 1 && p == 1));
          expv = trig ? 1'b0 : ((s == 2 && mb == 3'b100) ? 1'b1 : prev);
          chk(line_o[p], expv,
              trig ? (p == 0 ? "R4" : "R5") : (s == 2 ? "R7" : (mb[2] && mb[1] ? "R8" : "R9")),
              "level after stimulus");
          chk(line_chg_o[p], expv ^ prev, "R3", "change after stimulus");
          prev = expv;
          clr(); tick();
          expv = (trig && mb == 3'b101) ? 1'b1 : prev;
          chk(line_o[p], expv, "R6", "level one cycle later");
          chk(line_chg_o[p], expv ^ prev, "R3", "change one cycle later");
        end
      end
    end

    // R7: held strobe on port 1, released by first-input pulse
    clr(); set_ctl(1, 8'h20); tick();
    clr(); data_wr_i[1] = 1'b1; tick();
    clr(); tick(); tick();
    chk(line_o[1], 1'b0, "R7", "held low without pulse");
    clr(); c1_act_i[1] = 1'b1; tick();
    chk(line_o[1], 1'b1, "R7", "released by pulse");
    // R11: access beats first-input pulse
    clr(); data_wr_i[1] = 1'b1; c1_act_i[1] = 1'b1; tick();
    chk(line_o[1], 1'b0, "R11", "access wins over pulse");
    // R11: control write beats access (port 0 restore mode)
    clr(); set_ctl(0, 8'h28); tick();
    clr(); set_ctl(0, 8'h38); data_rd_i[0] = 1'b1; tick();
    chk(line_o[0], 1'b1, "R11", "control write wins over access");
    chk(c2_out_o[0], 1'b1, "R10", "flag after priority write");
    clr(); set_ctl(0, 8'h08); tick();
    chk(c2_out_o[0], 1'b0, "R10", "flag cleared by input-mode write");
    chk(line_o[0], 1'b1, "R9", "input-mode write keeps level");
    clr(); tick();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule